// File: doc/BRIEF.md
# Floating-Point Fraction Extraction Unit

This block is a small execution unit that holds eight 32-bit registers and carries out one operation on them: it takes a single-precision IEEE-754 value from a source register and returns its fractional part, in the same format, to a destination register. The integer bits are removed by truncation toward zero, and the sign of the input is kept. The remaining fraction bits are renormalised with a leading-zero count and a left shift.

An instruction is offered as one 32-bit word with a qualifying strobe. Words whose fixed bits do not match the operation's encoding are dropped. Accepted words pass through a two-state pipeline controller. State `PIPE_IDLE` means no result is pending. State `PIPE_BUSY` means the extraction stage holds an operand, and that operand is normalised and written back at the next clock edge. The transitions are:

- `accept`: `PIPE_IDLE` to `PIPE_BUSY` when a valid word arrives.
- `stream`: `PIPE_BUSY` to `PIPE_BUSY` when another word arrives directly behind the first.
- `drain`: `PIPE_BUSY` to `PIPE_IDLE` when no word arrives.

A separate load port writes registers directly, and a read port observes any register combinationally. The unit has no status outputs and keeps no flags. No hazard between the delay slot and the destination is detected.

Top module: `frac_unit`

## Requirements
- R1: A word is accepted only when `issue_valid` is high, bits 15:0 equal 0xE6F1 and bits 31:22 are all zero. Bits 21:19 select the source register and bits 18:16 select the destination register.
- R2: For a word sampled at clock edge E0, the destination still reads its old value between E0 and E1. It reads the result after the next edge E1.
- R3: An input whose exponent field is between 1 and 126 (magnitude below 1.0) is written unchanged.
- R4: An input whose exponent field is 150 to 254 has no fraction bits and yields a zero that carries the input's sign bit.
- R5: For exponent field e in 127..149, the low 150−e mantissa bits form the fraction f. When f is not zero and has lz leading zeros in its 23-bit field, the result exponent is e−1−lz and the mantissa is f shifted left by lz+1 within 23 bits. For example, 0x419D0000 gives 0x3F200000.
- R6: The result's sign bit equals the input's sign bit. Truncation is toward zero, so 0xC19D0000 gives 0xBF200000.
- R7: When the fraction bits of an input with exponent field 127..149 are all zero, the result is a zero with the input's sign.
- R8: An exponent field of 0 (zero or denormal) or 255 (infinity or NaN) gives a zero with the input's sign.
- R9: A word that fails the R1 match, or is offered with `issue_valid` low, writes no register.
- R10: A load writes `ld_data` into register `ld_idx` at the next edge. If a writeback targets the same register at that edge, the writeback value is kept. If the writeback targets a different register, both writes happen.
- R11: Words may be accepted on consecutive cycles, and each one completes with its own result.
- R12: Reset clears all eight registers to zero and leaves the controller in `PIPE_IDLE`.
- R13: Every written-back result has an exponent field below 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Qualifies `issue_word` this cycle |
| issue_word | input | 32 | Instruction word |
| ld_en | input | 1 | Direct register load strobe |
| ld_idx | input | 3 | Register index for the load |
| ld_data | input | 32 | Value to load |
| rd_idx | input | 3 | Register index to observe |
| rd_data | output | 32 | Combinational contents of register `rd_idx` |

## Verification
The pipeline writeback and a direct load can both target the register file at the same clock edge. The bench provokes this by issuing a word and then, in the delay slot, driving a load whose index is first the destination register and then a different register. It judges the outcome by reading both registers afterwards. In the first case it expects the extracted fraction to win. In the second case it expects both values to be present.

// File: rtl/frac_pkg.sv
package frac_pkg;

    localparam int unsigned FP_DW     = 32;
    localparam int unsigned FP_EW     = 8;
    localparam int unsigned FP_MW     = 23;
    localparam int unsigned FP_BIAS   = 127;
    localparam int unsigned FP_NREG   = 8;
    localparam logic [15:0] FP_OPC_LO = 16'hE6F1;

    // Classification of an operand after integer-bit removal
    typedef enum logic [1:0] {
        FK_PASS = 2'd0,
        FK_ZERO = 2'd1,
        FK_NORM = 2'd2
    } frac_kind_e;

    // Pipeline controller states
    typedef enum logic {
        PIPE_IDLE = 1'b0,
        PIPE_BUSY = 1'b1
    } pipe_state_e;

endpackage

// File: rtl/frac_decode.sv
module frac_decode #(
    parameter int unsigned DW     = 32,
    parameter int unsigned IDX_W  = 3,
    parameter logic [15:0] OPC_LO = 16'hE6F1
) (
    input  logic             valid,
    input  logic [DW-1:0]    word,
    output logic             ok,
    output logic [IDX_W-1:0] src,
    output logic [IDX_W-1:0] dst
);
    localparam int unsigned DST_LSB = 16;
    localparam int unsigned SRC_LSB = DST_LSB + IDX_W;
    localparam int unsigned PAD_LSB = SRC_LSB + IDX_W;

    logic low_match;
    logic pad_zero;

    always_comb begin
        low_match = (word[15:0] == OPC_LO);
        pad_zero  = (word[DW-1:PAD_LSB] == '0);
        ok        = valid && low_match && pad_zero;
        src       = word[SRC_LSB +: IDX_W];
        dst       = word[DST_LSB +: IDX_W];
    end

endmodule

// File: rtl/frac_regfile.sv
module frac_regfile #(
    parameter int unsigned NREG = 8,
    parameter int unsigned DW   = 32,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [DW-1:0]    ld_data,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [DW-1:0]    wb_data,
    input  logic [IDX_W-1:0] rs_idx,
    output logic [DW-1:0]    rs_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[g] <= '0;
            end else if (wb_en && (wb_idx == IDX_W'(g))) begin
                q[g] <= wb_data;
            end else if (ld_en && (ld_idx == IDX_W'(g))) begin
                q[g] <= ld_data;
            end
        end
    end

    assign rs_data = q[rs_idx];
    assign rd_data = q[rd_idx];

    // R10
    wb_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (q[$past(wb_idx)] == $past(wb_data)));

    // R10
    ld_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !(wb_en && (wb_idx == ld_idx))) |=> (q[$past(ld_idx)] == $past(ld_data)));

endmodule

// File: rtl/frac_extract.sv
module frac_extract
    import frac_pkg::*;
#(
    parameter int unsigned EW   = 8,
    parameter int unsigned MW   = 23,
    parameter int unsigned BIAS = 127,
    localparam int unsigned DW  = 1 + EW + MW
) (
    input  logic [DW-1:0] operand,
    output frac_kind_e    kind,
    output logic          sign,
    output logic [EW-1:0] expo,
    output logic [MW-1:0] frac
);
    localparam logic [EW-1:0] BIAS_V = EW'(BIAS);
    localparam logic [EW-1:0] LIM_V  = EW'(BIAS + MW);

    logic [MW-1:0] mant;
    logic [EW-1:0] int_bits;
    logic [MW-1:0] keep_mask;

    always_comb begin
        sign      = operand[DW-1];
        expo      = operand[MW +: EW];
        mant      = operand[MW-1:0];
        int_bits  = expo - BIAS_V;
        keep_mask = {MW{1'b1}} >> int_bits;
        frac      = '0;
        kind      = FK_ZERO;
        if ((expo == '0) || (expo == '1)) begin
            kind = FK_ZERO;
        end else if (expo < BIAS_V) begin
            kind = FK_PASS;
        end else if (expo >= LIM_V) begin
            kind = FK_ZERO;
        end else begin
            frac = mant & keep_mask;
            kind = (frac == '0) ? FK_ZERO : FK_NORM;
        end
    end

endmodule

// File: rtl/frac_normalise.sv
module frac_normalise
    import frac_pkg::*;
#(
    parameter int unsigned EW  = 8,
    parameter int unsigned MW  = 23,
    localparam int unsigned DW  = 1 + EW + MW,
    localparam int unsigned LZW = $clog2(MW)
) (
    input  frac_kind_e    kind,
    input  logic          sign,
    input  logic [EW-1:0] expo,
    input  logic [MW-1:0] frac,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] result
);
    logic [LZW-1:0] lz;
    logic [MW-1:0]  mant_n;
    logic [EW-1:0]  expo_n;

    function automatic logic [LZW-1:0] count_lz(input logic [MW-1:0] v);
        logic [LZW-1:0] n;
        logic           hit;
        n   = '0;
        hit = 1'b0;
        for (int i = 0; i < MW; i++) begin
            if (!hit && v[MW-1-i]) begin
                n   = LZW'(i);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

    always_comb begin
        lz     = count_lz(frac);
        mant_n = frac << (lz + LZW'(1));
        expo_n = expo - EW'(lz) - EW'(1);
        unique case (kind)
            FK_PASS: result = raw;
            FK_NORM: result = {sign, expo_n, mant_n};
            default: result = {sign, {(DW-1){1'b0}}};
        endcase
    end

endmodule

// File: rtl/frac_unit.sv
module frac_unit
    import frac_pkg::*;
#(
    parameter int unsigned NREG   = FP_NREG,
    parameter int unsigned EW     = FP_EW,
    parameter int unsigned MW     = FP_MW,
    parameter int unsigned BIAS   = FP_BIAS,
    parameter logic [15:0] OPC_LO = FP_OPC_LO,
    localparam int unsigned DW    = 1 + EW + MW,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [DW-1:0]    issue_word,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [DW-1:0]    ld_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    logic             accept;
    logic [IDX_W-1:0] dec_src;
    logic [IDX_W-1:0] dec_dst;
    logic [DW-1:0]    src_val;

    frac_kind_e       x_kind;
    logic             x_sign;
    logic [EW-1:0]    x_expo;
    logic [MW-1:0]    x_frac;

    // extraction stage register
    frac_kind_e       s_kind;
    logic             s_sign;
    logic [EW-1:0]    s_expo;
    logic [MW-1:0]    s_frac;
    logic [DW-1:0]    s_raw;
    logic [IDX_W-1:0] s_dst;

    pipe_state_e      state;
    pipe_state_e      state_nx;
    logic             wb_en;
    logic [DW-1:0]    wb_data;

    frac_decode #(.DW(DW), .IDX_W(IDX_W), .OPC_LO(OPC_LO)) u_dec (
        .valid (issue_valid),
        .word  (issue_word),
        .ok    (accept),
        .src   (dec_src),
        .dst   (dec_dst)
    );

    frac_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .wb_en   (wb_en),
        .wb_idx  (s_dst),
        .wb_data (wb_data),
        .rs_idx  (dec_src),
        .rs_data (src_val),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    frac_extract #(.EW(EW), .MW(MW), .BIAS(BIAS)) u_ext (
        .operand (src_val),
        .kind    (x_kind),
        .sign    (x_sign),
        .expo    (x_expo),
        .frac    (x_frac)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_kind <= FK_ZERO;
            s_sign <= 1'b0;
            s_expo <= '0;
            s_frac <= '0;
            s_raw  <= '0;
            s_dst  <= '0;
        end else if (accept) begin
            s_kind <= x_kind;
            s_sign <= x_sign;
            s_expo <= x_expo;
            s_frac <= x_frac;
            s_raw  <= src_val;
            s_dst  <= dec_dst;
        end
    end

    frac_normalise #(.EW(EW), .MW(MW)) u_norm (
        .kind   (s_kind),
        .sign   (s_sign),
        .expo   (s_expo),
        .frac   (s_frac),
        .raw    (s_raw),
        .result (wb_data)
    );

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PIPE_IDLE;
        else        state <= state_nx;
    end

    // controller: next state (accept / stream / drain)
    always_comb begin
        state_nx = state;
        unique case (state)
            PIPE_IDLE: state_nx = accept ? PIPE_BUSY : PIPE_IDLE;
            PIPE_BUSY: state_nx = accept ? PIPE_BUSY : PIPE_IDLE;
            default:   state_nx = PIPE_IDLE;
        endcase
    end

    // controller: outputs
    always_comb begin
        unique case (state)
            PIPE_BUSY: wb_en = 1'b1;
            default:   wb_en = 1'b0;
        endcase
    end

    // R2
    wb_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(accept));

    // R9
    no_stray_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !wb_en);

    // R13
    below_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_data[DW-2 -: EW] < EW'(BIAS)));

    // R6
    sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_data[DW-1] == s_raw[DW-1]));

    // R11
    stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && accept) |=> wb_en);

endmodule

// File: tb/frac_unit_tb.sv
`timescale 1ns/1ps
module frac_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_word = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;

    frac_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_word  (issue_word),
        .ld_en       (ld_en),
        .ld_idx      (ld_idx),
        .ld_data     (ld_data),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data)
    );

    always #2 clk = ~clk;

    localparam int NV = 16;
    localparam logic [31:0] VIN [NV] = '{
        32'h419D0000, // R5  19.625
        32'hC19D0000, // R6  -19.625
        32'h3F200000, // R3  0.625
        32'h40400000, // R7  3.0
        32'hC0400000, // R7  -3.0
        32'h4B000001, // R4  exponent 150
        32'hCB7FFFFF, // R4  negative, large
        32'h7F800000, // R8  +inf
        32'hFF800000, // R8  -inf
        32'h7FC00000, // R8  NaN
        32'h00000001, // R8  denormal
        32'h80000001, // R8  negative denormal
        32'h3FC00000, // R5  1.5
        32'h40100000, // R5  2.25
        32'h4A800001, // R5  2^22 + 0.5
        32'h3F800000  // R7  1.0
    };
    localparam logic [31:0] VEXP [NV] = '{
        32'h3F200000, 32'hBF200000, 32'h3F200000, 32'h00000000,
        32'h80000000, 32'h00000000, 32'h80000000, 32'h00000000,
        32'h80000000, 32'h00000000, 32'h00000000, 32'h80000000,
        32'h3F000000, 32'h3E800000, 32'h3F000000, 32'h00000000
    };
    localparam int VREQ [NV] = '{5, 6, 3, 7, 7, 4, 4, 8, 8, 8, 8, 8, 5, 5, 5, 7};

    function automatic logic [31:0] mkword(input logic [2:0] s, input logic [2:0] d);
        return {10'b0, s, d, 16'hE6F1};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] idx, output logic [31:0] val);
        rd_idx = idx;
        #0.5;
        val = rd_data;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        repeat (3) @(negedge clk);
        // R12: all registers zero after reset
        for (int r = 0; r < 8; r++) begin
            peek(3'(r), v);
            check("R12", v, 32'h0);
        end
        rst_n = 1'b1;
        idle(2);

        // vector table: src R2, dst R3, delay-slot check each time
        for (int i = 0; i < NV; i++) begin
            load(3'd2, VIN[i]);
            load(3'd3, 32'hDEADBEEF);
            issue_valid = 1'b1; issue_word = mkword(3'd2, 3'd3);
            @(posedge clk);          // E0
            @(negedge clk);
            issue_valid = 1'b0;
            peek(3'd3, v);
            check("R2", v, 32'hDEADBEEF);
            @(posedge clk);          // E1
            @(negedge clk);
            peek(3'd3, v);
            checks++;
            if (v !== VEXP[i]) begin
                failures++;
                $display("FAIL R%0d vector %0d actual=%08h expected=%08h", VREQ[i], i, v, VEXP[i]);
            end
        end

        // R1: other register fields decode correctly (src R7 -> dst R0)
        load(3'd7, 32'hC19D0000);
        @(negedge clk);
        issue_valid = 1'b1; issue_word = mkword(3'd7, 3'd0);
        @(negedge clk);
        issue_valid = 1'b0;
        idle(1);
        peek(3'd0, v);
        check("R1", v, 32'hBF200000);

        // R9: wrong low half, stray upper bit, and valid low
        load(3'd5, 32'h12345678);
        load(3'd6, 32'h419D0000);
        @(negedge clk);
        issue_valid = 1'b1; issue_word = mkword(3'd6, 3'd5) ^ 32'h00000001;
        @(negedge clk);
        issue_word = mkword(3'd6, 3'd5) | 32'h00400000;
        @(negedge clk);
        issue_valid = 1'b0; issue_word = mkword(3'd6, 3'd5);
        idle(3);
        peek(3'd5, v);
        check("R9", v, 32'h12345678);

        // R11: back-to-back issues
        load(3'd0, 32'h419D0000);
        load(3'd1, 32'h40100000);
        @(negedge clk);
        issue_valid = 1'b1; issue_word = mkword(3'd0, 3'd4);
        @(negedge clk);
        issue_word = mkword(3'd1, 3'd5);
        @(negedge clk);
        issue_valid = 1'b0;
        idle(1);
        peek(3'd4, v);
        peek(3'd5, v2);
        check("R11", v, 32'h3F200000);
        check("R11", v2, 32'h3E800000);

        // R10: load in the delay slot to the destination: writeback wins
        load(3'd2, 32'h3FC00000);
        @(negedge clk);
        issue_valid = 1'b1; issue_word = mkword(3'd2, 3'd6);
        @(negedge clk);
        issue_valid = 1'b0;
        ld_en = 1'b1; ld_idx = 3'd6; ld_data = 32'h11111111;
        @(negedge clk);
        ld_en = 1'b0;
        peek(3'd6, v);
        check("R10", v, 32'h3F000000);

        // R10: load to a different register in the same cycle: both land
        @(negedge clk);
        issue_valid = 1'b1; issue_word = mkword(3'd2, 3'd6);
        @(negedge clk);
        issue_valid = 1'b0;
        ld_en = 1'b1; ld_idx = 3'd7; ld_data = 32'h22222222;
        @(negedge clk);
        ld_en = 1'b0;
        peek(3'd6, v);
        peek(3'd7, v2);
        check("R10", v, 32'h3F000000);
        check("R10", v2, 32'h22222222);

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule